// File: doc/BRIEF.md
# Two-Wire Serial Target with High-Speed Mode Tracking

This block is the serial target front end of a programmable reference-voltage device. It watches the SCL and SDA lines through synchronisers clocked by a fast system clock. It finds start, stop and repeated-start conditions and shifts in each byte on the rising SCL edges. It then decides, byte by byte, whether to pull SDA low in the acknowledge slot. SCL is only ever an input, and the target never stretches the clock or returns read data.

Three kinds of address byte are understood. The first is the device's own write address, 111010x, where the strap input supplies x. The second is the general-call address 00h. The third is the high-speed master code 00001xxx, which is never acknowledged; it raises a mode flag that survives repeated starts and drops at the next stop. After the device's own address, every data byte is passed to a register block on a one-cycle valid strobe, with a marker on the first byte of the transfer. After general call, data byte 06h is acknowledged and produces a one-cycle internal reset pulse. Any other general-call data byte is refused.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset, sda_pull_o, hs_mode_o, rx_valid_o, rx_first_o and gc_reset_o are all 0.
- R2: An address byte with bits [7:1] equal to 111010 followed by the addr_sel_i level, and with bit 0 (write) equal to 0, is acknowledged: SDA is held low during the ninth SCL clock. Any other non-special address byte is not acknowledged.
- R3: The device's own address with bit 0 equal to 1 (read) is not acknowledged, and the following bytes produce no rx_valid_o.
- R4: After an acknowledged own address, each received data byte is acknowledged and appears on rx_data_o, MSB first on the wire, with a one-cycle rx_valid_o. rx_first_o is 1 only with the first byte after the address.
- R5: An address byte whose upper five bits are 00001 is not acknowledged whatever its low three bits are, and it sets hs_mode_o to 1.
- R6: hs_mode_o stays 1 through repeated starts and any bytes that follow them, and it returns to 0 after a stop condition.
- R7: The general-call address 00h is always acknowledged.
- R8: After general call, data byte 06h is acknowledged and gc_reset_o pulses high for exactly one clock. Any other general-call data byte is not acknowledged and gives no pulse.
- R9: A start seen in the middle of a byte discards the partial byte and begins a new address phase. A stop seen in the middle of a byte returns the target to idle with no rx_valid_o.
- R10: sda_pull_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Strap level used as the address LSB |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| hs_mode_o | output | 1 | High-speed mode active |
| rx_data_o | output | 8 | Received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| rx_first_o | output | 1 | Strobed byte is the first after the address |
| gc_reset_o | output | 1 | One-cycle internal reset request |

## Verification
The hardest states to reach are those where a bus condition arrives while the engine is mid-byte, or while the high-speed flag must outlive several repeated starts. The bench builds these with a bit-level master that can stop after any number of bits and then issue a repeated start or a stop. It follows the aborted transfer with a fresh address and a data byte that the scoreboard expects with the first-byte marker set. The high-speed sequence chains the master code, a repeated start, an addressed write and a second repeated start. It samples the mode flag after each step and again after the closing stop.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  localparam int BYTE_W = 8;

  // fixed upper part of the device address, strap supplies the LSB
  localparam logic [5:0] DEV_ADDR_HI  = 6'b111010;
  localparam logic [4:0] HS_PREFIX    = 5'b00001;
  localparam logic [7:0] GC_ADDR      = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SKIP
  } eng_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_OWN,
    K_GC
  } byte_kind_t;

  typedef struct packed {
    logic       ack;
    logic       hs_set;
    logic       gc_pulse;
    logic       data_out;
    logic       set_first;
    byte_kind_t next_kind;
  } byte_dec_t;

endpackage

// File: rtl/i2ct_rst_sync.sv
module i2ct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/i2ct_line_mon.sv
module i2ct_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] cur;
  logic [N_LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw[g]};
      end
      assign cur[g] = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= cur;
  end

  assign scl_hi    = cur[0];
  assign sda_lvl   = cur[1];
  assign scl_rise  = cur[0] & ~prev_q[0];
  assign scl_fall  = ~cur[0] & prev_q[0];
  // SDA moving while SCL stayed high over both samples
  assign start_det = cur[0] & prev_q[0] & prev_q[1] & ~cur[1];
  assign stop_det  = cur[0] & prev_q[0] & ~prev_q[1] & cur[1];

endmodule

// File: rtl/i2ct_decode.sv
module i2ct_decode
  import i2ct_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  byte_kind_t        kind_i,
  input  logic              addr_sel_i,
  output byte_dec_t         dec_o
);

  always_comb begin
    dec_o           = '0;
    dec_o.next_kind = kind_i;
    unique case (kind_i)
      K_ADDR: begin
        if (byte_i[7:3] == HS_PREFIX) begin
          dec_o.hs_set = 1'b1;
        end else if (byte_i == GC_ADDR) begin
          dec_o.ack       = 1'b1;
          dec_o.next_kind = K_GC;
        end else if (byte_i[7:1] == {DEV_ADDR_HI, addr_sel_i} && !byte_i[0]) begin
          dec_o.ack       = 1'b1;
          dec_o.set_first = 1'b1;
          dec_o.next_kind = K_OWN;
        end
      end
      K_GC: begin
        if (byte_i == GC_RESET_CMD) begin
          dec_o.ack      = 1'b1;
          dec_o.gc_pulse = 1'b1;
        end
      end
      K_OWN: begin
        dec_o.ack      = 1'b1;
        dec_o.data_out = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_hi_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  byte_dec_t         dec_i,
  output logic [BITS-1:0]   shift_o,
  output byte_kind_t        kind_o,
  output logic              sda_pull_o,
  output logic              hs_mode_o,
  output logic [BITS-1:0]   rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  output logic              gc_reset_o
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);

  eng_state_t       state_q, state_d;
  byte_kind_t       kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BITS-1:0]  sh_q, sh_d;
  logic             oe_q, oe_d;
  logic             hs_q, hs_d;
  logic             first_q, first_d;
  logic [BITS-1:0]  rxd_q, rxd_d;
  logic             rxv_q, rxv_d;
  logic             rxf_q, rxf_d;
  logic             gc_q, gc_d;
  logic             cap_en;

  assign cap_en = rxv_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    hs_d    = hs_q;
    first_d = first_q;
    rxv_d   = 1'b0;
    rxf_d   = 1'b0;
    gc_d    = 1'b0;
    rxd_d   = sh_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
      hs_d    = 1'b0;
    end else if (start_i) begin
      state_d = ST_RECV;
      kind_d  = K_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise_i && cnt_q < CNT_FULL) begin
            sh_d  = {sh_q[BITS-2:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            hs_d = hs_q | dec_i.hs_set;
            if (dec_i.ack) begin
              state_d = ST_ACK;
              oe_d    = 1'b1;
              kind_d  = dec_i.next_kind;
              rxv_d   = dec_i.data_out;
              rxf_d   = dec_i.data_out & first_q;
              gc_d    = dec_i.gc_pulse;
              if (dec_i.set_first)     first_d = 1'b1;
              else if (dec_i.data_out) first_d = 1'b0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            state_d = ST_RECV;
            oe_d    = 1'b0;
            cnt_d   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      hs_q    <= 1'b0;
      first_q <= 1'b0;
      rxv_q   <= 1'b0;
      rxf_q   <= 1'b0;
      gc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      hs_q    <= hs_d;
      first_q <= first_d;
      rxv_q   <= rxv_d;
      rxf_q   <= rxf_d;
      gc_q    <= gc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= '0;
    else if (cap_en) rxd_q <= rxd_d;
  end

  assign shift_o    = sh_q;
  assign kind_o     = kind_q;
  assign sda_pull_o = oe_q;
  assign hs_mode_o  = hs_q;
  assign rx_data_o  = rxd_q;
  assign rx_valid_o = rxv_q;
  assign rx_first_o = rxf_q;
  assign gc_reset_o = gc_q;

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_hi_i);

  // R5
  hs_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !oe_q);

  // R6
  hs_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !hs_q);

  // R8
  gc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_q |=> !gc_q);

  // R8
  gc_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_q |-> oe_q);

  // R4
  rx_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> oe_q);

endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic              hs_mode_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  output logic              gc_reset_o
);

  logic              rst_n_s;
  logic              scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] shift_byte;
  byte_kind_t        kind;
  byte_dec_t         dec;

  i2ct_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  i2ct_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_hi    (scl_hi),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2ct_decode u_dec (
    .byte_i     (shift_byte),
    .kind_i     (kind),
    .addr_sel_i (addr_sel_i),
    .dec_o      (dec)
  );

  i2ct_engine #(.BITS(BYTE_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_hi_i   (scl_hi),
    .sda_i      (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .dec_i      (dec),
    .shift_o    (shift_byte),
    .kind_o     (kind),
    .sda_pull_o (sda_pull_o),
    .hs_mode_o  (hs_mode_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_first_o (rx_first_o),
    .gc_reset_o (gc_reset_o)
  );

endmodule

// File: tb/tb_i2c_hs_target.sv
`timescale 1ns/1ps
module tb_i2c_hs_target;

  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_bus;
  logic       sda_pull, hs_mode, rx_valid, rx_first, gc_reset;
  logic [7:0] rx_data;

  int n_run = 0, n_fail = 0, gc_cnt = 0, rx_cnt = 0, r10_bad = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  logic pull_prev = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_hs_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .hs_mode_o(hs_mode),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_first_o(rx_first),
    .gc_reset_o(gc_reset)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected rx byte", {23'd0, rx_first, rx_data}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({rx_first, rx_data} == e, "R4 rx byte/first", {23'd0, rx_first, rx_data}, {23'd0, e});
        end
      end
      if (gc_reset) gc_cnt++;
      if (sda_pull != pull_prev && scl_m) r10_bad++;
      pull_prev <= sda_pull;
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H / 2);
    acked = !sda_bus;
    tick(H / 2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic push_exp(input logic [7:0] d, input logic f);
    exp_q.push_back({f, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    int g0, r0;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R1 reset state
    chk({sda_pull, hs_mode, rx_valid, rx_first, gc_reset} == 5'b0, "R1 reset outputs",
        {sda_pull, hs_mode, rx_valid, rx_first, gc_reset}, 0);

    // R2 / R4 : strap low, own address 74h write
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hE8, a); chk(a, "R2 ack 74h strap0", a, 1);
    push_exp(8'h5A, 1'b1);
    send_byte(8'h5A, a); chk(a, "R4 ack data 5A", a, 1);
    push_exp(8'hC3, 1'b0);
    send_byte(8'hC3, a); chk(a, "R4 ack data C3", a, 1);
    bus_stop();
    tick(4);
    chk(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);

    // R2 : 75h not ours with strap low
    bus_start();
    send_byte(8'hEA, a); chk(!a, "R2 nack 75h strap0", a, 0);
    bus_stop();

    // R2 : strap high, 75h
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'hEA, a); chk(a, "R2 ack 75h strap1", a, 1);
    push_exp(8'h11, 1'b1);
    send_byte(8'h11, a); chk(a, "R4 ack data 11", a, 1);
    bus_stop();
    bus_start();
    send_byte(8'hE8, a); chk(!a, "R2 nack 74h strap1", a, 0);
    bus_stop();

    // R3 : read bit not acknowledged, no data strobes
    r0 = rx_cnt;
    bus_start();
    send_byte(8'hEB, a); chk(!a, "R3 nack read address", a, 0);
    send_byte(8'h77, a);
    bus_stop(); tick(4);
    chk(rx_cnt == r0, "R3 no rx after read address", rx_cnt, r0);

    // R5 / R6 : master code and mode persistence
    bus_start();
    send_byte(8'h0D, a); chk(!a, "R5 nack master code", a, 0);
    chk(hs_mode == 1'b1, "R5 hs set", hs_mode, 1);
    bus_rstart(); tick(4);
    chk(hs_mode == 1'b1, "R6 hs after repeated start", hs_mode, 1);
    send_byte(8'hEA, a); chk(a, "R6 ack own address in hs", a, 1);
    push_exp(8'h22, 1'b1);
    send_byte(8'h22, a);
    bus_rstart(); tick(4);
    chk(hs_mode == 1'b1, "R6 hs after second repeated start", hs_mode, 1);
    bus_stop(); tick(4);
    chk(hs_mode == 1'b0, "R6 hs cleared by stop", hs_mode, 0);
    bus_start();
    send_byte(8'h08, a); chk(!a && hs_mode, "R5 nack master code low bits 000", a, 0);
    bus_stop(); tick(4);

    // R7 / R8 : general call reset
    g0 = gc_cnt;
    bus_start();
    send_byte(8'h00, a); chk(a, "R7 ack general call", a, 1);
    send_byte(8'h06, a); chk(a, "R8 ack 06h", a, 1);
    bus_stop(); tick(4);
    chk(gc_cnt == g0 + 1, "R8 one reset pulse", gc_cnt, g0 + 1);
    bus_start();
    send_byte(8'h00, a); chk(a, "R7 ack general call again", a, 1);
    send_byte(8'h07, a); chk(!a, "R8 nack 07h", a, 0);
    bus_stop(); tick(4);
    chk(gc_cnt == g0 + 1, "R8 no pulse on 07h", gc_cnt, g0 + 1);

    // R9 : start mid-byte aborts
    bus_start();
    send_byte(8'hEA, a);
    send_bits(8'hF0, 4);
    bus_rstart();
    send_byte(8'hEA, a); chk(a, "R9 address after abort", a, 1);
    push_exp(8'h33, 1'b1);
    send_byte(8'h33, a); chk(a, "R9 ack data after abort", a, 1);
    bus_stop(); tick(4);

    // R9 : stop mid-byte
    r0 = rx_cnt;
    bus_start();
    send_byte(8'hEA, a);
    send_bits(8'hA5, 3);
    bus_stop(); tick(4);
    chk(rx_cnt == r0 && !sda_pull, "R9 stop mid-byte no rx", rx_cnt, r0);
    bus_start();
    send_byte(8'hEA, a); chk(a, "R9 idle then new transfer", a, 1);
    bus_stop(); tick(4);

    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
    chk(r10_bad == 0, "R10 pull changes with SCL low", r10_bad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule